// File: doc/BRIEF.md
# Pre-trigger circular capture controller

This block records a stream of 8-bit converter samples into an external ring memory. Each valid sample goes to the next ring address, and the address wraps from the top of the ring back to zero, so the record always holds the most recent history. A 4-bit setting, taken when a start request arrives, splits the ring into a part kept from before the trigger and a part filled after it. Once the trigger has been seen and the programmed number of post-trigger samples has been stored, writing stops and the address of the final sample is held on an output.

After capture, the block unrolls the ring into a second, linear memory. The oldest sample goes to linear address 0 and the newest to the top address. The ring is read through a port with one cycle of latency. When the copy has finished, a done flag rises and stays up until the next start request. A saturating count of stored samples tells the user how much of the record holds real data when the trigger came before the ring had filled once.

Top module: `trig_ring_capture`

## Requirements
- R1: While armed, each cycle with `smp_valid_i` high writes `smp_data_i` to the ring. The first write after a start goes to address 0, each later write goes to the previous address plus one, and address DEPTH-1 is followed by 0.
- R2: Samples and triggers that arrive while the block is not armed (before any start, during the unroll, or after done) cause no ring write and leave `done_o` and `last_addr_o` unchanged.
- R3: The post-trigger length is (16 - setting) * DEPTH/16 samples, so a setting of 0 gives DEPTH. A sample taken in the same cycle as `trig_i`, or in any later cycle, counts as post-trigger. Capture stops right after the last post-trigger sample has been written. A trigger in a cycle with no valid sample still arms the count.
- R4: A trigger is accepted even before the ring has filled once. `fill_cnt_o` counts the samples written since start and saturates at DEPTH.
- R5: `last_addr_o` gives the ring address of the final post-trigger sample and holds it until the next start.
- R6: The unroll writes linear address i with the ring word at (last_addr + 1 + i) mod DEPTH, for i = 0 to DEPTH-1, in rising order. Ring read data arrives one cycle after the read address.
- R7: `done_o` rises on the cycle after the last linear write, which is DEPTH+1 clock edges after the edge that stores the final sample. It stays high until a start request.
- R8: A start request clears `done_o`, the fill count and the trigger latch, and arms the block on the next edge. The setting is sampled only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| pre_set_i | input | SET_W | Pre-trigger setting, sampled at start |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Sample value |
| trig_i | input | 1 | Trigger |
| cap_we_o | output | 1 | Ring write enable |
| cap_addr_o | output | ADDR_W | Ring write address |
| cap_data_o | output | DATA_W | Ring write data |
| cap_rd_addr_o | output | ADDR_W | Ring read address for unroll |
| cap_rd_data_i | input | DATA_W | Ring read data, one cycle latency |
| lin_we_o | output | 1 | Linear memory write enable |
| lin_addr_o | output | ADDR_W | Linear memory address |
| lin_data_o | output | DATA_W | Linear memory data |
| busy_o | output | 1 | Armed or unrolling |
| done_o | output | 1 | Unroll complete |
| last_addr_o | output | ADDR_W | Ring address of the last stored sample |
| fill_cnt_o | output | ADDR_W+1 | Saturating count of stored samples |

## Verification
The bench counts ring writes. A controller that stops one sample early or late shows up there, because samples keep arriving during the unroll and would be stored. It runs a case with a wrapped record, a case with setting 0 where the whole ring is post-trigger, and a case where a lone trigger comes before the ring has filled. An off-by-one in the rotation start or in the read-latency alignment appears as a shifted linear image. A trigger latch that survives a restart would cut the next record short. A design that still accepts samples after done would change the write count or the held last address.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COPY  = 2'd2,
        ST_DONE  = 2'd3
    } trc_state_e;
endpackage

// File: rtl/trc_ring_writer.sv
module trc_ring_writer #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              trig_i,
    input  logic [CNT_W-1:0]  post_len_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] last_o,
    output logic [CNT_W-1:0]  fill_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] wptr;
        logic [CNT_W-1:0]  fill;
        logic              trig_seen;
        logic [CNT_W-1:0]  post_cnt;
        logic [ADDR_W-1:0] last;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      trig_now;

    always_comb begin
        s_d      = s_q;
        we_o     = 1'b0;
        stop_o   = 1'b0;
        trig_now = s_q.trig_seen | trig_i;
        if (clear_i) begin
            s_d.wptr      = '0;
            s_d.fill      = '0;
            s_d.trig_seen = 1'b0;
            s_d.post_cnt  = '0;
        end else if (en_i) begin
            s_d.trig_seen = trig_now;
            if (smp_valid_i) begin
                we_o     = 1'b1;
                s_d.wptr = s_q.wptr + 1'b1;
                if (s_q.fill != CNT_W'(DEPTH)) begin
                    s_d.fill = s_q.fill + 1'b1;
                end
                if (trig_now) begin
                    s_d.post_cnt = s_q.post_cnt + 1'b1;
                    if (s_q.post_cnt + 1'b1 == post_len_i) begin
                        stop_o   = 1'b1;
                        s_d.last = s_q.wptr;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o = s_q.wptr;
    assign data_o = smp_data_i;
    assign last_o = s_q.last;
    assign fill_o = s_q.fill;

    // R1: consecutive writes go to consecutive ring addresses
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && !clear_i) |=> (addr_o == $past(addr_o) + 1'b1));

    // R4: fill count never passes the ring depth
    a_r4_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CNT_W'(DEPTH));

    // R5: held last address only moves while capturing or on a clear
    a_r5_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clear_i) |=> $stable(last_o));
endmodule

// File: rtl/trc_unroller.sv
module trc_unroller #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              lin_we_o,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic [DATA_W-1:0] lin_data_o,
    output logic              finish_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } un_state_t;

    un_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        finish_o = 1'b0;
        if (clear_i) begin
            s_d.run = 1'b0;
            s_d.cnt = '0;
        end else if (go_i) begin
            s_d.run = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.run) begin
            if (s_q.cnt == CNT_W'(DEPTH)) begin
                s_d.run  = 1'b0;
                finish_o = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_addr_o  = base_i + 1'b1 + s_q.cnt[ADDR_W-1:0];
    assign lin_we_o   = s_q.run && (s_q.cnt != '0);
    assign lin_addr_o = ADDR_W'(s_q.cnt - 1'b1);
    assign lin_data_o = rd_data_i;

    // R6: linear writes walk upward one address per cycle
    a_r6_lin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_we_o && s_q.cnt != CNT_W'(DEPTH) && !clear_i && !go_i)
        |=> (lin_we_o && lin_addr_o == $past(lin_addr_o) + 1'b1));

    // R6: the first linear write lands at address 0
    a_r6_lin_first: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !clear_i) |=> ##1 (lin_we_o && lin_addr_o == '0));
endmodule

// File: rtl/trig_ring_capture.sv
module trig_ring_capture
    import trc_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int SET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SET_W-1:0]  pre_set_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              trig_i,
    output logic              cap_we_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [DATA_W-1:0] cap_data_o,
    output logic [ADDR_W-1:0] cap_rd_addr_o,
    input  logic [DATA_W-1:0] cap_rd_data_i,
    output logic              lin_we_o,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic [DATA_W-1:0] lin_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] last_addr_o,
    output logic [ADDR_W:0]   fill_cnt_o
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int NSEG  = 1 << SET_W;
    localparam int SEG   = (1 << ADDR_W) / NSEG;

    typedef struct packed {
        trc_state_e       st;
        logic [SET_W-1:0] set;
    } top_state_t;

    top_state_t       s_d, s_q;
    logic             stop;
    logic             finish;
    logic [CNT_W-1:0] post_len;

    assign post_len = CNT_W'((NSEG - int'(s_q.set)) * SEG);

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.st  = ST_ARMED;
            s_d.set = pre_set_i;
        end else begin
            case (s_q.st)
                ST_ARMED: if (stop)   s_d.st = ST_COPY;
                ST_COPY:  if (finish) s_d.st = ST_DONE;
                default:  s_d.st = s_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, set: '0};
        end else begin
            s_q <= s_d;
        end
    end

    trc_ring_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .en_i       (s_q.st == ST_ARMED),
        .smp_valid_i(smp_valid_i),
        .smp_data_i (smp_data_i),
        .trig_i     (trig_i),
        .post_len_i (post_len),
        .we_o       (cap_we_o),
        .addr_o     (cap_addr_o),
        .data_o     (cap_data_o),
        .stop_o     (stop),
        .last_o     (last_addr_o),
        .fill_o     (fill_cnt_o)
    );

    trc_unroller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_unroller (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .go_i      (stop && !start_i),
        .base_i    (last_addr_o),
        .rd_addr_o (cap_rd_addr_o),
        .rd_data_i (cap_rd_data_i),
        .lin_we_o  (lin_we_o),
        .lin_addr_o(lin_addr_o),
        .lin_data_o(lin_data_o),
        .finish_o  (finish)
    );

    assign busy_o = (s_q.st == ST_ARMED) || (s_q.st == ST_COPY);
    assign done_o = (s_q.st == ST_DONE);

    // R2: no ring write outside the armed phase
    a_r2_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_ARMED) |-> !cap_we_o);

    // R7: done holds until a start request
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R7: no linear write once done
    a_r7_no_lin_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !lin_we_o);

    // R8: a start request drops done and arms the block
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && busy_o && fill_cnt_o == '0));
endmodule

// File: tb/test_trig_ring_capture.sv
module test_trig_ring_capture;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int SW = 4;
    localparam int D  = 1 << AW;
    localparam int SEG = D / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] pre_set_i = '0;
    logic          smp_valid_i = 1'b0;
    logic [DW-1:0] smp_data_i = '0;
    logic          trig_i = 1'b0;
    logic          cap_we_o;
    logic [AW-1:0] cap_addr_o;
    logic [DW-1:0] cap_data_o;
    logic [AW-1:0] cap_rd_addr_o;
    logic [DW-1:0] cap_rd_data_i;
    logic          lin_we_o;
    logic [AW-1:0] lin_addr_o;
    logic [DW-1:0] lin_data_o;
    logic          busy_o;
    logic          done_o;
    logic [AW-1:0] last_addr_o;
    logic [AW:0]   fill_cnt_o;

    trig_ring_capture #(.ADDR_W(AW), .DATA_W(DW), .SET_W(SW)) i_trig_ring_capture (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pre_set_i(pre_set_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i),
        .cap_we_o(cap_we_o), .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o),
        .cap_rd_addr_o(cap_rd_addr_o), .cap_rd_data_i(cap_rd_data_i),
        .lin_we_o(lin_we_o), .lin_addr_o(lin_addr_o), .lin_data_o(lin_data_o),
        .busy_o(busy_o), .done_o(done_o), .last_addr_o(last_addr_o),
        .fill_cnt_o(fill_cnt_o)
    );

    always #5 clk = ~clk;

    logic [DW-1:0] ring [D];
    logic [DW-1:0] lin  [D];
    logic [DW-1:0] model[D];
    int wr_cnt = 0;
    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit ended = 1'b0;

    initial begin
        for (int i = 0; i < D; i++) begin
            ring[i]  = '0;
            lin[i]   = '0;
            model[i] = '0;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        cap_rd_data_i <= ring[cap_rd_addr_o];
        if (cap_we_o) begin
            ring[cap_addr_o] <= cap_data_o;
            wr_cnt <= wr_cnt + 1;
        end
        if (lin_we_o) lin[lin_addr_o] <= lin_data_o;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        finish_run();
    end

    task automatic t_reset();
        @(negedge clk);
        check("R8 reset done", int'(done_o), 0);
        check("R8 reset busy", int'(busy_o), 0);
        check("R1 reset we", int'(cap_we_o), 0);
        check("R4 reset fill", int'(fill_cnt_o), 0);
    endtask

    // Full capture: start, pre samples, trigger, post samples, unroll
    task automatic t_capture(input int set, input int pre, input bit trig_alone,
                             input int seed);
        int post = (16 - set) * SEG;
        int total = pre + post;
        int wp = 0;
        int w0;
        int steps;
        int bad;
        int exp_last;
        @(negedge clk);
        start_i = 1'b1;
        pre_set_i = SW'(set);
        @(negedge clk);
        start_i = 1'b0;
        pre_set_i = ~SW'(set);   // R8: later value must be ignored
        check("R8 start clears done", int'(done_o), 0);
        check("R8 start clears fill", int'(fill_cnt_o), 0);
        w0 = wr_cnt;
        for (int k = 0; k < pre; k++) begin
            if (k % 5 == 4) begin
                smp_valid_i = 1'b0;
                @(negedge clk);
            end
            smp_valid_i = 1'b1;
            smp_data_i = DW'(seed * 7 + k * 13);
            model[wp % D] = smp_data_i;
            wp++;
            @(negedge clk);
        end
        if (trig_alone) begin
            smp_valid_i = 1'b0;
            trig_i = 1'b1;
            @(negedge clk);
            trig_i = 1'b0;
        end
        for (int k = 0; k < post; k++) begin
            smp_valid_i = 1'b1;
            trig_i = (!trig_alone && k == 0);
            smp_data_i = DW'(seed * 11 + k * 5 + 3);
            model[wp % D] = smp_data_i;
            wp++;
            if (k < post - 1) @(negedge clk);
        end
        @(posedge clk);
        #1;
        trig_i = 1'b0;
        steps = 0;
        while (!done_o && steps < 4 * D) begin
            smp_valid_i = (steps < 4);   // R2: samples during unroll ignored
            trig_i = (steps < 4);
            @(posedge clk);
            #1;
            steps++;
        end
        smp_valid_i = 1'b0;
        trig_i = 1'b0;
        exp_last = (total - 1) % D;
        check("R3 write count", wr_cnt - w0, total);
        check("R7 done latency", steps, D + 1);
        check("R5 last addr", int'(last_addr_o), exp_last);
        check("R4 fill count", int'(fill_cnt_o), (total < D) ? total : D);
        check("R7 busy low at done", int'(busy_o), 0);
        bad = 0;
        for (int i = 0; i < D; i++) begin
            if (lin[i] != model[(exp_last + 1 + i) % D]) bad++;
        end
        check("R6 linear image mismatches", bad, 0);
        check("R1 ring matches model", int'(ring[exp_last]), int'(model[exp_last]));
    endtask

    task automatic t_ignored_after_done();
        int w0 = wr_cnt;
        logic [AW-1:0] l0 = last_addr_o;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_valid_i = 1'b1;
            trig_i = 1'b1;
            smp_data_i = 8'hA5;
        end
        @(negedge clk);
        smp_valid_i = 1'b0;
        trig_i = 1'b0;
        @(negedge clk);
        check("R2 no writes after done", wr_cnt - w0, 0);
        check("R2 done kept", int'(done_o), 1);
        check("R2 last addr kept", int'(last_addr_o), int'(l0));
        check("R7 done holds", int'(done_o), 1);
    endtask

    task automatic t_ignored_idle();
        int w0 = wr_cnt;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            smp_valid_i = 1'b1;
            trig_i = 1'b1;
        end
        @(negedge clk);
        smp_valid_i = 1'b0;
        trig_i = 1'b0;
        @(negedge clk);
        check("R2 no writes idle", wr_cnt - w0, 0);
        check("R2 idle not done", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ignored_idle();
        t_capture(8, 40, 1'b0, 1);    // R3 wrapped record, half pre-trigger
        t_ignored_after_done();
        t_capture(0, 5, 1'b0, 2);     // R3 setting 0: whole ring post-trigger
        t_capture(15, 2, 1'b1, 3);    // R4 early lone trigger, R8 latch cleared
        t_ignored_after_done();
        finish_run();
    end
endmodule